// File: doc/BRIEF.md
# Spread Spectrum Offset Generator

This block produces a small signed offset that is added to the fine frequency-control word of a digitally controlled oscillator. Moving that word slowly back and forth spreads the oscillator's output energy over a band of frequencies instead of a single line. The block does not model the oscillator or its lock loop. It supplies the offset and the fine word with the offset already applied and saturated, so it serves open-loop and closed-loop operation alike.

The offset advances on a single-cycle modulation tick that is synchronous to the system clock. As an option, each tick can be kept or dropped according to one bit of an internal pseudo-random sequence. The amplitude setting selects one of three behaviours. An amplitude of zero makes the offset toggle between 0 and 1. An amplitude of one cycles the offset through a fixed three-entry pattern. A larger amplitude makes the offset sweep as a triangle between the positive and negative amplitude, moving by the configured step on each tick.

Top module: `spread_offset_gen`

## Requirements
- R1: Synchronous active-low reset. While `rst_n` is low at a clock edge, the edge sets the offset to 0, clears both sticky flags, sets the sweep direction to up, sets the pattern index to its first entry and loads the random-sequence register with 7'h01.
- R2: The effective step is 1 when `cfg_step` is 0 or 1. Otherwise it equals `cfg_step`.
- R3: With `cfg_amp` = 0, each qualified tick sets the offset to 1 if it was 0, and to 0 otherwise.
- R4: With `cfg_amp` = 1, successive qualified ticks produce +1, -1, 0 and then repeat. The pattern starts from +1 after reset or after `cfg_en` has been low.
- R5: With `cfg_amp` > 1, a qualified tick forms a candidate value, which is the offset plus the step when the direction is up and the offset minus the step when it is down. A candidate at or above +amp gives +amp and turns the direction down. A candidate at or below -amp gives -amp and turns the direction up. Any other candidate is taken as it is.
- R6: The random sequence comes from a 7-bit register s. On every raw tick it shifts left, and s[6] XOR s[5] enters at bit 0 (polynomial x^7+x^6+1). An all-zero state reloads 7'h01. With `cfg_prbs_en` = 1, a tick is qualified only if s[6] is 1 before that tick's shift.
- R7: The offset changes only on a qualified tick while `cfg_en` is 1, or when `cfg_en` is low. The step and amplitude settings are sampled only at qualified ticks.
- R8: While `cfg_en` is 0, the next edge sets the offset to 0, the direction to up and the pattern index to its first entry. This happens even when a tick arrives in the same cycle.
- R9: `fine_out` equals `fine_in` plus the signed offset, limited to the range 0 to 2^FINE_W-1. It follows `fine_in` with no register delay.
- R10: `sat_hi_flag` and `sat_lo_flag` go to 1 on the edge after a cycle in which the sum is above the maximum or below zero, respectively. They stay at 1 while `cfg_en` is 1, and `cfg_en` low clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mod_tick | input | 1 | Raw modulation tick, one cycle wide |
| cfg_en | input | 1 | Generator enable |
| cfg_prbs_en | input | 1 | Qualify ticks with the pseudo-random bit |
| cfg_step | input | STEP_W (4) | Step size |
| cfg_amp | input | AMP_W (6) | Amplitude setting |
| fine_in | input | FINE_W (10) | Unsigned fine control word |
| offset_out | output | OFS_W (8) | Signed offset, two's complement |
| fine_out | output | FINE_W (10) | Fine word with the offset added, saturated |
| sat_hi_flag | output | 1 | Sticky flag: the sum was limited at the top |
| sat_lo_flag | output | 1 | Sticky flag: the sum was limited at zero |

## Verification
Two events can fall in the same cycle. A tick can arrive in the cycle where `cfg_en` is dropped, and a sweep step can arrive in the cycle where the sum saturates. The bench drives a tick together with a low enable. It then expects a zero offset, a cleared flag and a fresh pattern start at the next edge. It also steps the sweep past the top and bottom codes of `fine_in`, and a reference model compares offset, fine word and both flags after every edge.

// File: rtl/ssg_pkg.sv
// Package: types and constants shared by the spread spectrum offset generator.
// Assumes a 7-bit random sequence; the tap pair is maximal only for that width.
package ssg_pkg;
    typedef enum logic {
        SWEEP_UP   = 1'b0,
        SWEEP_DOWN = 1'b1
    } sweep_dir_e;

    localparam int          PRBS_W    = 7;
    localparam logic [6:0]  PRBS_SEED = 7'h01;
    localparam int          TRI_IDX_W = 2;
endpackage

// File: rtl/ssg_lfsr.sv
// Module: ssg_lfsr
// Fibonacci shift register, x^W + x^(W-1) + 1, advancing once per raw tick.
// Assumes W = 7 for a maximal sequence. A zero state (unreachable) reloads SEED.
module ssg_lfsr #(
    parameter int           W    = 7,
    parameter logic [W-1:0] SEED = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    output logic bit_o
);
    logic [W-1:0] state;

    // Purpose: shift the sequence register on every raw tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= SEED;
        else if (state == '0)
            state <= SEED;
        else if (adv)
            state <= {state[W-2:0], state[W-1] ^ state[W-2]};
    end

    // Purpose: expose the qualifying bit before the shift.
    assign bit_o = state[W-1];
endmodule

// File: rtl/ssg_sweep.sv
// Module: ssg_sweep
// Holds the signed offset and moves it on qualified ticks. There are three
// behaviours: LSB toggle (amp 0), the fixed +1/-1/0 pattern (amp 1) and a
// clamped triangle (amp > 1). Assumes OFS_W is wide enough for amp + step.
module ssg_sweep
    import ssg_pkg::*;
#(
    parameter int STEP_W = 4,
    parameter int AMP_W  = 6,
    parameter int OFS_W  = AMP_W + 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic                    qual,
    input  logic [STEP_W-1:0]       step,
    input  logic [AMP_W-1:0]        amp,
    output logic signed [OFS_W-1:0] ofs
);
    sweep_dir_e             dir_q, dir_d;
    logic [TRI_IDX_W-1:0]   idx_q, idx_d;
    logic signed [OFS_W-1:0] ofs_d, amp_s, step_s, cand;

    // Purpose: sign-safe widening of the settings and the effective step.
    always_comb begin
        amp_s  = $signed({{(OFS_W-AMP_W){1'b0}}, amp});
        step_s = (step < 2) ? OFS_W'(1)
                            : $signed({{(OFS_W-STEP_W){1'b0}}, step});
        cand   = (dir_q == SWEEP_DOWN) ? ofs - step_s : ofs + step_s;
    end

    // Purpose: choose the next offset, direction and index.
    always_comb begin
        ofs_d = ofs;
        dir_d = dir_q;
        idx_d = idx_q;
        if (!en) begin
            ofs_d = '0;
            dir_d = SWEEP_UP;
            idx_d = '0;
        end else if (qual) begin
            if (amp == '0) begin
                ofs_d = (ofs == '0) ? OFS_W'(1) : '0;
            end else if (amp == AMP_W'(1)) begin
                case (idx_q)
                    2'd0:    ofs_d = OFS_W'(1);
                    2'd1:    ofs_d = -OFS_W'(1);
                    default: ofs_d = '0;
                endcase
                idx_d = (idx_q >= 2'd2) ? 2'd0 : idx_q + 2'd1;
            end else if (cand >= amp_s) begin
                ofs_d = amp_s;
                dir_d = SWEEP_DOWN;
            end else if (cand <= -amp_s) begin
                ofs_d = -amp_s;
                dir_d = SWEEP_UP;
            end else begin
                ofs_d = cand;
            end
        end
    end

    // Purpose: register the sweep state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ofs   <= '0;
            dir_q <= SWEEP_UP;
            idx_q <= '0;
        end else begin
            ofs   <= ofs_d;
            dir_q <= dir_d;
            idx_q <= idx_d;
        end
    end
endmodule

// File: rtl/ssg_sat_add.sv
// Module: ssg_sat_add
// Adds a signed offset to an unsigned fine word and limits the result to
// 0 .. 2^FINE_W-1. Purely combinational. Reports which limit applied.
module ssg_sat_add #(
    parameter int FINE_W = 10,
    parameter int OFS_W  = 8
) (
    input  logic [FINE_W-1:0]       fine,
    input  logic signed [OFS_W-1:0] ofs,
    output logic [FINE_W-1:0]       sum_o,
    output logic                    hi_o,
    output logic                    lo_o
);
    localparam int SUM_W = ((FINE_W > OFS_W) ? FINE_W : OFS_W) + 2;

    logic signed [SUM_W-1:0] sum;

    // Purpose: widen, add and clamp.
    always_comb begin
        sum   = $signed({{(SUM_W-FINE_W){1'b0}}, fine}) + SUM_W'(ofs);
        hi_o  = sum > $signed({{(SUM_W-FINE_W){1'b0}}, {FINE_W{1'b1}}});
        lo_o  = sum < 0;
        if (hi_o)
            sum_o = '1;
        else if (lo_o)
            sum_o = '0;
        else
            sum_o = sum[FINE_W-1:0];
    end
endmodule

// File: rtl/spread_offset_gen.sv
// Module: spread_offset_gen (top)
// Spread spectrum offset generator for a fine oscillator control word.
// Assumes mod_tick is a single-cycle pulse synchronous to clk.
module spread_offset_gen
    import ssg_pkg::*;
#(
    parameter int   FINE_W = 10,
    parameter int   STEP_W = 4,
    parameter int   AMP_W  = 6,
    localparam int  OFS_W  = AMP_W + 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    mod_tick,
    input  logic                    cfg_en,
    input  logic                    cfg_prbs_en,
    input  logic [STEP_W-1:0]       cfg_step,
    input  logic [AMP_W-1:0]        cfg_amp,
    input  logic [FINE_W-1:0]       fine_in,
    output logic signed [OFS_W-1:0] offset_out,
    output logic [FINE_W-1:0]       fine_out,
    output logic                    sat_hi_flag,
    output logic                    sat_lo_flag
);
    logic prbs_bit, tick_ok, hi_now, lo_now;

    ssg_lfsr #(.W(PRBS_W), .SEED(PRBS_SEED)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (mod_tick),
        .bit_o (prbs_bit)
    );

    // Purpose: qualify the raw tick by enable and the optional random bit.
    assign tick_ok = mod_tick && cfg_en && (!cfg_prbs_en || prbs_bit);

    ssg_sweep #(.STEP_W(STEP_W), .AMP_W(AMP_W), .OFS_W(OFS_W)) u_sweep (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (cfg_en),
        .qual  (tick_ok),
        .step  (cfg_step),
        .amp   (cfg_amp),
        .ofs   (offset_out)
    );

    ssg_sat_add #(.FINE_W(FINE_W), .OFS_W(OFS_W)) u_add (
        .fine  (fine_in),
        .ofs   (offset_out),
        .sum_o (fine_out),
        .hi_o  (hi_now),
        .lo_o  (lo_now)
    );

    // Purpose: sticky saturation flags, cleared while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !cfg_en) begin
            sat_hi_flag <= 1'b0;
            sat_lo_flag <= 1'b0;
        end else begin
            sat_hi_flag <= sat_hi_flag | hi_now;
            sat_lo_flag <= sat_lo_flag | lo_now;
        end
    end
endmodule

// File: rtl/ssg_checker.sv
// Module: ssg_checker
// Temporal properties of spread_offset_gen, attached by bind.
module ssg_checker #(
    parameter int FINE_W = 10,
    parameter int AMP_W  = 6,
    parameter int OFS_W  = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    mod_tick,
    input logic                    cfg_en,
    input logic                    cfg_prbs_en,
    input logic [AMP_W-1:0]        cfg_amp,
    input logic [FINE_W-1:0]       fine_in,
    input logic signed [OFS_W-1:0] offset_out,
    input logic [FINE_W-1:0]       fine_out,
    input logic                    sat_hi_flag
);
    // R8
    disable_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> offset_out == '0);

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en && !mod_tick) |=> $stable(offset_out));

    // R5
    tri_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en && mod_tick && !cfg_prbs_en && cfg_amp > 1) |=>
        (offset_out <= $signed({2'b00, $past(cfg_amp)}) &&
         offset_out >= -$signed({2'b00, $past(cfg_amp)})));

    // R9
    sum_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (offset_out >= 0) |-> fine_out >= fine_in);

    // R10
    hi_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_hi_flag && cfg_en) |=> sat_hi_flag);
endmodule

bind spread_offset_gen ssg_checker #(
    .FINE_W(FINE_W), .AMP_W(AMP_W), .OFS_W(OFS_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mod_tick    (mod_tick),
    .cfg_en      (cfg_en),
    .cfg_prbs_en (cfg_prbs_en),
    .cfg_amp     (cfg_amp),
    .fine_in     (fine_in),
    .offset_out  (offset_out),
    .fine_out    (fine_out),
    .sat_hi_flag (sat_hi_flag)
);

// File: tb/spread_offset_gen_bench.sv
// Scoreboard bench: drive() pushes expectations, a monitor compares them.
module spread_offset_gen_bench;
    localparam int FINE_W = 10;
    localparam int STEP_W = 4;
    localparam int AMP_W  = 6;
    localparam int OFS_W  = AMP_W + 2;
    localparam int FMAX   = (1 << FINE_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mod_tick = 1'b0, cfg_en = 1'b0, cfg_prbs_en = 1'b0;
    logic [STEP_W-1:0] cfg_step = '0;
    logic [AMP_W-1:0]  cfg_amp = '0;
    logic [FINE_W-1:0] fine_in = '0;
    logic signed [OFS_W-1:0] offset_out;
    logic [FINE_W-1:0] fine_out;
    logic sat_hi_flag, sat_lo_flag;

    int checks = 0, errors = 0;
    int q_ofs[$], q_fo[$], q_hi[$], q_lo[$];
    string q_req[$];

    // model state
    int m_ofs = 0, m_dir = 0, m_idx = 0, m_hi = 0, m_lo = 0;
    logic [6:0] m_lfsr = 7'h01;
    // settings applied by drive()
    int t_en = 0, t_prbs = 0, t_step = 0, t_amp = 0, t_fine = 0;

    spread_offset_gen #(.FINE_W(FINE_W), .STEP_W(STEP_W), .AMP_W(AMP_W))
    u_spread_offset_gen (
        .clk(clk), .rst_n(rst_n), .mod_tick(mod_tick), .cfg_en(cfg_en),
        .cfg_prbs_en(cfg_prbs_en), .cfg_step(cfg_step), .cfg_amp(cfg_amp),
        .fine_in(fine_in), .offset_out(offset_out), .fine_out(fine_out),
        .sat_hi_flag(sat_hi_flag), .sat_lo_flag(sat_lo_flag)
    );

    always #2 clk = ~clk;

    function automatic int clampf(input int v);
        if (v > FMAX) return FMAX;
        if (v < 0) return 0;
        return v;
    endfunction

    function automatic void check(input string rq, input string what,
                                  input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", rq, what, act, exp);
        end
    endfunction

    // Driver: one cycle of stimulus plus its expected outcome.
    task automatic drive(input logic tk, input string rq);
        int s, n, cand;
        logic qual;
        @(negedge clk);
        mod_tick    = tk;
        cfg_en      = t_en[0];
        cfg_prbs_en = t_prbs[0];
        cfg_step    = STEP_W'(t_step);
        cfg_amp     = AMP_W'(t_amp);
        fine_in     = FINE_W'(t_fine);
        s = t_fine + m_ofs;
        if (t_en == 0) begin
            m_hi = 0; m_lo = 0;
        end else begin
            if (s > FMAX) m_hi = 1;
            if (s < 0) m_lo = 1;
        end
        qual = tk && (t_en != 0) && (t_prbs == 0 || m_lfsr[6]);
        if (tk) m_lfsr = {m_lfsr[5:0], m_lfsr[6] ^ m_lfsr[5]};
        if (t_en == 0) begin
            m_ofs = 0; m_dir = 0; m_idx = 0;
        end else if (qual) begin
            if (t_amp == 0) m_ofs = (m_ofs == 0) ? 1 : 0;
            else if (t_amp == 1) begin
                m_ofs = (m_idx == 0) ? 1 : (m_idx == 1) ? -1 : 0;
                m_idx = (m_idx + 1) % 3;
            end else begin
                n = (t_step < 2) ? 1 : t_step;
                cand = m_dir ? m_ofs - n : m_ofs + n;
                if (cand >= t_amp) begin m_ofs = t_amp; m_dir = 1; end
                else if (cand <= -t_amp) begin m_ofs = -t_amp; m_dir = 0; end
                else m_ofs = cand;
            end
        end
        q_ofs.push_back(m_ofs);
        q_fo.push_back(clampf(t_fine + m_ofs));
        q_hi.push_back(m_hi);
        q_lo.push_back(m_lo);
        q_req.push_back(rq);
    endtask

    task automatic ticks(input int k, input string rq);
        for (int i = 0; i < k; i++) begin
            drive(1'b1, rq);
            drive(1'b0, rq);
        end
    endtask

    // Monitor: compare outputs a nanosecond after each edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q_ofs.size() > 0) begin
                string rq;
                rq = q_req.pop_front();
                check(rq, "offset", int'(offset_out), q_ofs.pop_front());
                check(rq, "fine_out", int'(fine_out), q_fo.pop_front());
                check(rq, "sat_hi", int'(sat_hi_flag), q_hi.pop_front());
                check(rq, "sat_lo", int'(sat_lo_flag), q_lo.pop_front());
            end
        end
    end

    // Watchdog
    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", "offset", int'(offset_out), 0);
        check("R1", "sat_hi", int'(sat_hi_flag), 0);
        check("R1", "sat_lo", int'(sat_lo_flag), 0);
        check("R1", "fine_out", int'(fine_out), 0);

        t_en = 1; t_fine = 512; t_amp = 1; t_step = 0;
        ticks(7, "R4");                       // +1,-1,0 repeating
        drive(1'b0, "R7"); drive(1'b0, "R7");  // no tick: hold
        t_amp = 0;
        ticks(5, "R3");                       // LSB toggle
        // R8: tick in the same cycle as enable low
        t_en = 0; drive(1'b1, "R8");
        t_en = 1; t_amp = 1; ticks(2, "R8");  // pattern restarts at +1
        t_amp = 5; t_step = 0; ticks(14, "R5");
        t_step = 1; ticks(4, "R2");
        t_step = 2; ticks(10, "R2");
        t_amp = 20; t_step = 7; ticks(12, "R5");
        t_amp = 3; drive(1'b0, "R7");         // shrink: no effect without tick
        ticks(6, "R7");
        t_en = 0; drive(1'b0, "R8");
        t_en = 1; t_prbs = 1; t_amp = 9; t_step = 1;
        ticks(40, "R6");
        t_prbs = 0; t_fine = 1020; t_amp = 9; t_step = 3;
        ticks(12, "R10");                     // top saturation
        t_fine = 1010; ticks(3, "R9");
        t_fine = 2; ticks(12, "R10");         // bottom saturation
        t_en = 0; drive(1'b0, "R10");          // clears flags
        t_en = 1; t_fine = 300; ticks(4, "R9");
        drive(1'b0, "R9");
        wait (q_ofs.size() == 0);
        @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule